// File: doc/BRIEF.md
# SMRAM Window Access Router

This block sits in the memory decode path of a host bridge. It decides where an access to the 64 KB system management memory window should go: to DRAM or to the PCI bus. Software sets one control byte through a simple register write port. That byte holds the window selection, an open bit, a close bit and a lock bit. Each access arrives with its address, a flag that says whether the processor is in system management mode, and a flag that says whether it is a code fetch or a data access.

The routing result is registered. It appears one cycle after the access is presented, together with a flag saying whether the access fell inside the active window. Inside the window, SMM code fetches always reach DRAM. SMM data accesses can be pushed out to PCI with the close bit. Outside SMM, the window is visible only when software has opened it, and only for the A segment. After the lock bit is set, the open bit and the window selection are frozen until system reset.

Top module: `smram_router`

## Requirements
- R1: After synchronous reset the control byte reads 0x02 (A segment selected, not open, not closed, unlocked), and route_valid, route_hit and route_dram are 0.
- R2: The control byte reads back with this layout: bit 5 open, bit 4 close, bit 3 lock, bits 2:0 window code. Bits 7:6 always read 0, whatever value was written.
- R3: Window code 3'b010 selects addresses 0xA0000 to 0xAFFFF. Code 3'b011 selects 0xB0000 to 0xBFFFF. An access inside the selected range gives route_hit = 1.
- R4: With any window code other than 3'b010 or 3'b011, no access hits, and every access gives route_hit = 0 and route_dram = 0 (PCI).
- R5: An access outside the selected window gives route_hit = 0 and route_dram = 0.
- R6: An in-window code fetch (acc_code = 1) made in SMM goes to DRAM (route_dram = 1) whatever the close bit holds.
- R7: An in-window data access (acc_code = 0) made in SMM goes to DRAM when the close bit is 0 and to PCI when it is 1.
- R8: An in-window access made outside SMM goes to DRAM only when the open bit is 1 and the window code is 3'b010. Otherwise it goes to PCI.
- R9: Writing 1 to the lock bit sets it. Later writes of 0 do not clear it. Only reset clears it.
- R10: While locked, the open bit reads 0, writes to the open bit and window code are ignored, and the close bit stays writable. A write that sets the lock stores a 0 open bit and takes its window code.
- R11: A result is registered. route_valid is 1 exactly in the cycle after a cycle with acc_valid = 1. Routing uses the control byte as it stood in the access cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte write data |
| cfg_rdata | output | 8 | Current control byte |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | ADDR_W | Access byte address |
| acc_smm | input | 1 | Processor is in system management mode |
| acc_code | input | 1 | 1 = code fetch, 0 = data access |
| route_valid | output | 1 | Registered result valid |
| route_hit | output | 1 | Access fell inside the active window |
| route_dram | output | 1 | 1 = route to DRAM, 0 = route to PCI |

## Verification
Some properties are checked on every cycle. These are the stickiness of the lock, the forced-zero open bit once locked, the frozen window code under locked writes, the zero reserved bits, the one-cycle result timing, and DRAM routing for SMM code fetches and for non-SMM accesses. Other behaviour shows only in the bench's scenarios, which compare against a reference model: the exact address boundaries of each segment, the effect of the rejected window codes, the close bit splitting SMM data from code, and the fact that only reset clears a lock.

// File: rtl/smram_pkg.sv
package smram_pkg;

  localparam logic [2:0] WIN_CODE_A = 3'b010;
  localparam logic [2:0] WIN_CODE_B = 3'b011;

  typedef struct packed {
    logic       open;
    logic       close;
    logic       lock;
    logic [2:0] win;
  } smram_ctl_t;

  localparam smram_ctl_t CTL_RESET = '{open: 1'b0, close: 1'b0, lock: 1'b0, win: WIN_CODE_A};

  function automatic logic [7:0] ctl_to_byte(input smram_ctl_t c);
    return {2'b00, c.open, c.close, c.lock, c.win};
  endfunction

endpackage

// File: rtl/smram_ctl_reg.sv
module smram_ctl_reg
  import smram_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [7:0] wdata,
  output smram_ctl_t ctl,
  output logic [7:0] rdata
);

  smram_ctl_t ctl_q;
  logic       unused_wbits;

  assign unused_wbits = ^wdata[7:6];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= CTL_RESET;
    end else if (wr) begin
      ctl_q.close <= wdata[4];
      if (ctl_q.lock) begin
        ctl_q.open <= 1'b0;
      end else begin
        ctl_q.open <= wdata[5] & ~wdata[3];
        ctl_q.lock <= wdata[3];
        ctl_q.win  <= wdata[2:0];
      end
    end
  end

  assign ctl   = ctl_q;
  assign rdata = ctl_to_byte(ctl_q);

  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_q.lock |=> ctl_q.lock);

  // R10
  locked_closed_open_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_q.lock |-> !ctl_q.open);

  // R10
  locked_win_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.lock && wr) |=> $stable(ctl_q.win));

  // R2
  always_comb begin
    if (!rst) reserved_zero_chk: assert (rdata[7:6] == 2'b00);
  end

endmodule

// File: rtl/smram_win_dec.sv
module smram_win_dec
  import smram_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 32,
  parameter int unsigned       WIN_AW     = 16,
  parameter logic [ADDR_W-1:0] SEG_A_BASE = 'h000A_0000,
  parameter logic [ADDR_W-1:0] SEG_B_BASE = 'h000B_0000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        win,
  output logic              hit,
  output logic              hit_a
);

  localparam int unsigned NSEG  = 2;
  localparam int unsigned TAG_W = ADDR_W - WIN_AW;

  logic [NSEG-1:0] seg_hit;
  logic [TAG_W-1:0] addr_tag;
  logic             unused_low;

  assign addr_tag   = addr[ADDR_W-1:WIN_AW];
  assign unused_low = ^addr[WIN_AW-1:0];

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    localparam logic [ADDR_W-1:0] BASE = (s == 0) ? SEG_A_BASE : SEG_B_BASE;
    localparam logic [2:0]        CODE = (s == 0) ? WIN_CODE_A : WIN_CODE_B;
    assign seg_hit[s] = (win == CODE) && (addr_tag == BASE[ADDR_W-1:WIN_AW]);
  end

  assign hit   = |seg_hit;
  assign hit_a = seg_hit[0];

  // R3
  always_comb begin
    seg_onehot_chk: assert ($onehot0(seg_hit));
  end

endmodule

// File: rtl/smram_route.sv
module smram_route
  import smram_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic valid,
  input  logic hit,
  input  logic hit_a,
  input  logic smm,
  input  logic code,
  input  logic open,
  input  logic close,
  output logic out_valid,
  output logic out_hit,
  output logic out_dram
);

  logic dram_d;

  always_comb begin
    if (!hit)     dram_d = 1'b0;
    else if (smm) dram_d = code | ~close;
    else          dram_d = open & hit_a;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_dram  <= 1'b0;
    end else begin
      out_valid <= valid;
      out_hit   <= valid & hit;
      out_dram  <= valid & dram_d;
    end
  end

  // R11
  result_follows_chk: assert property (@(posedge clk) disable iff (rst)
    valid |=> out_valid);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |=> (!out_valid && !out_hit && !out_dram));

  // R6
  smm_fetch_dram_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && hit && smm && code) |=> out_dram);

  // R8
  normal_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && !smm && !(open && hit_a)) |=> !out_dram);

  // R5
  miss_pci_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && !hit) |=> (!out_hit && !out_dram));

endmodule

// File: rtl/smram_router.sv
module smram_router
  import smram_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 32,
  parameter int unsigned       WIN_AW     = 16,
  parameter logic [ADDR_W-1:0] SEG_A_BASE = 'h000A_0000,
  parameter logic [ADDR_W-1:0] SEG_B_BASE = 'h000B_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_smm,
  input  logic              acc_code,
  output logic              route_valid,
  output logic              route_hit,
  output logic              route_dram
);

  smram_ctl_t ctl;
  logic       hit;
  logic       hit_a;

  smram_ctl_reg u_ctl (
    .clk   (clk),
    .rst   (rst),
    .wr    (cfg_wr),
    .wdata (cfg_wdata),
    .ctl   (ctl),
    .rdata (cfg_rdata)
  );

  smram_win_dec #(
    .ADDR_W     (ADDR_W),
    .WIN_AW     (WIN_AW),
    .SEG_A_BASE (SEG_A_BASE),
    .SEG_B_BASE (SEG_B_BASE)
  ) u_dec (
    .addr  (acc_addr),
    .win   (ctl.win),
    .hit   (hit),
    .hit_a (hit_a)
  );

  smram_route u_route (
    .clk       (clk),
    .rst       (rst),
    .valid     (acc_valid),
    .hit       (hit),
    .hit_a     (hit_a),
    .smm       (acc_smm),
    .code      (acc_code),
    .open      (ctl.open),
    .close     (ctl.close),
    .out_valid (route_valid),
    .out_hit   (route_hit),
    .out_dram  (route_dram)
  );

  // R8
  dram_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
    route_dram |-> route_hit);

endmodule

// File: tb/smram_router_test.sv
module smram_router_test;

  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_wr = 1'b0;
  logic [7:0]        cfg_wdata = '0;
  logic [7:0]        cfg_rdata;
  logic              acc_valid = 1'b0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic              acc_smm = 1'b0;
  logic              acc_code = 1'b0;
  logic              route_valid, route_hit, route_dram;

  int   checks = 0;
  int   failures = 0;
  logic [7:0] model = 8'h02;

  always #4 clk = ~clk;

  smram_router uut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_smm(acc_smm), .acc_code(acc_code), .route_valid(route_valid),
    .route_hit(route_hit), .route_dram(route_dram)
  );

  function automatic logic [7:0] ctl_next(input logic [7:0] cur, input logic [7:0] wd);
    if (cur[3]) return {2'b00, 1'b0, wd[4], 1'b1, cur[2:0]};
    return {2'b00, wd[5] & ~wd[3], wd[4], wd[3], wd[2:0]};
  endfunction

  function automatic logic exp_hit(input logic [7:0] c, input logic [31:0] a);
    if (c[2:0] == 3'b010) return a[31:16] == 16'h000A;
    if (c[2:0] == 3'b011) return a[31:16] == 16'h000B;
    return 1'b0;
  endfunction

  function automatic logic exp_dram(input logic [7:0] c, input logic [31:0] a,
                                    input logic smm, input logic code);
    if (!exp_hit(c, a)) return 1'b0;
    if (smm) return code | ~c[4];
    return c[5] & (c[2:0] == 3'b010);
  endfunction

  function automatic string route_tag(input logic [7:0] c, input logic [31:0] a,
                                      input logic smm, input logic code);
    if (c[2:0] != 3'b010 && c[2:0] != 3'b011) return "R4";
    if (!exp_hit(c, a)) return "R5";
    if (smm && code) return "R6";
    if (smm) return "R7";
    return "R8";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cfg_wr = 1'b0; acc_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model = 8'h02;
  endtask

  task automatic do_write(input logic [7:0] b);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = b;
    @(negedge clk);
    cfg_wr = 1'b0;
    model = ctl_next(model, b);
    check(model[3] ? "R10" : "R2", {24'h0, cfg_rdata}, {24'h0, model});
  endtask

  task automatic do_access(input logic [31:0] a, input logic smm, input logic code);
    string t;
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_smm = smm; acc_code = code;
    @(negedge clk);
    acc_valid = 1'b0;
    t = route_tag(model, a, smm, code);
    check("R11", {31'h0, route_valid}, 32'h1);
    check("R3", {31'h0, route_hit}, {31'h0, exp_hit(model, a)});
    check(t, {31'h0, route_dram}, {31'h0, exp_dram(model, a, smm, code)});
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R1 reset state
    check("R1", {24'h0, cfg_rdata}, 32'h02);
    check("R1", {29'h0, route_valid, route_hit, route_dram}, 32'h0);

    // R2 reserved bits read zero
    do_write(8'hC2);
    // R3 segment A edges
    do_access(32'h000A_0000, 1'b1, 1'b0);
    do_access(32'h000A_FFFF, 1'b1, 1'b0);
    do_access(32'h0009_FFFF, 1'b1, 1'b0);
    // R3 segment B
    do_write(8'h03);
    do_access(32'h000B_0000, 1'b1, 1'b1);
    do_access(32'h000A_8000, 1'b1, 1'b1);
    do_access(32'h000C_0000, 1'b1, 1'b1);
    // R8 open only with A code
    do_write(8'h23);
    do_access(32'h000B_1234, 1'b0, 1'b0);
    do_write(8'h22);
    do_access(32'h000A_1234, 1'b0, 1'b0);
    do_access(32'h000A_1234, 1'b0, 1'b1);
    // R7 close splits data
    do_write(8'h12);
    do_access(32'h000A_0100, 1'b1, 1'b0);
    do_access(32'h000A_0100, 1'b1, 1'b1);
    do_access(32'h000A_0100, 1'b0, 1'b0);
    // R4 rejected codes
    do_write(8'h24);
    do_access(32'h000A_0000, 1'b1, 1'b1);
    do_write(8'h20);
    do_access(32'h000B_0000, 1'b0, 1'b0);
    // R11 idle cycle
    @(negedge clk);
    check("R11", {31'h0, route_valid}, 32'h0);

    // R9 / R10 lock
    do_write(8'h2A);
    check("R10", {31'h0, cfg_rdata[5]}, 32'h0);
    do_write(8'h00);
    check("R9", {31'h0, cfg_rdata[3]}, 32'h1);
    do_write(8'h33);
    check("R10", {29'h0, cfg_rdata[2:0]}, 32'h2);
    check("R10", {31'h0, cfg_rdata[4]}, 32'h1);
    do_access(32'h000A_4444, 1'b1, 1'b0);
    do_access(32'h000A_4444, 1'b0, 1'b0);
    do_reset();
    check("R9", {24'h0, cfg_rdata}, 32'h02);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int unsigned r = $urandom % 8;
      if (i % 400 == 399) do_reset();
      if (r < 2) begin
        logic [7:0] b = 8'($urandom);
        if (($urandom % 12) != 0) b[3] = 1'b0;
        if (($urandom % 3) != 0) b[2:1] = 2'b01;
        do_write(b);
      end else begin
        logic [31:0] a;
        int unsigned k = $urandom % 4;
        case (k)
          0: a = {16'h000A, 16'($urandom)};
          1: a = {16'h000B, 16'($urandom)};
          2: a = ($urandom % 2) ? 32'h0009_FFFF : 32'h000C_0000;
          default: a = $urandom;
        endcase
        do_access(a, 1'($urandom), 1'($urandom));
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule